// File: doc/BRIEF.md
# Windowed Head-of-Line Input Arbiter

This block schedules one switching slot of an input-buffered cell switch with `N_IN` inputs and as many outputs. Each input shows the arbiter the destination outputs of the first `WIN` cells in its queue, and a valid flag for each of those window entries. On each slot-start strobe the arbiter builds a matching. Each input gets at most one grant and each output accepts at most one cell. The grant says which window position to send and to which output.

Matching runs in `WIN` passes, shallowest depth first. Pass 0 matches front-of-queue cells. Each later pass looks one cell deeper, and only at inputs and outputs that no earlier pass has matched. When several inputs compete for one output within a pass, a round-robin pointer kept for each output picks the winner. A pointer moves only when its output is granted. With `WIN = 1` the block is a plain first-in-first-out head-of-line arbiter. Queue storage, out-of-order removal from a queue and the cell data path sit outside this block.

Top module: `wh_arbiter`

## Requirements
- R1: Coming out of reset, `grant_valid` is all zero, every `grant_pos` field is zero and every `grant_dest` field is zero. Every output pointer starts at input 0.
- R2: The grant produced from the requests present at a clock edge where `slot_start` is high appears on the outputs right after that edge. At edges where `slot_start` is low, the grant outputs keep their values.
- R3: Among the registered grants, no two valid grants name the same output.
- R4: When input i is granted, the window entry at `grant_pos` is valid and `grant_dest` equals that entry's destination. Window entry d of input i uses bit `i*WIN+d` of `req_valid` and field `(i*WIN+d)*DW +: DW` of `req_dest`. Input i's grant fields are `i*PW +: PW` and `i*DW +: DW`.
- R5: An entry whose valid bit is low is never granted. If no entry is valid, no grant is issued and no pointer moves.
- R6: Passes run in order of depth. An input matched at depth d is not considered at any deeper depth. An output matched at depth d takes no cell from any deeper depth.
- R7: The matching is maximal. If input i gets no grant and has a valid entry at any depth, that entry's output is granted to some other input.
- R8: Within a pass, output o grants the first eligible requesting input at or after its pointer, counting upward and wrapping. On a grant the pointer moves to the winner plus one, modulo `N_IN`. An output that grants nothing keeps its pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_start | input | 1 | Strobe that starts one arbitration slot |
| req_valid | input | N_IN*WIN | Valid flag of each window entry |
| req_dest | input | N_IN*WIN*DW | Destination output of each window entry |
| grant_valid | output | N_IN | Input has a grant in the current slot |
| grant_pos | output | N_IN*PW | Window depth of the granted cell |
| grant_dest | output | N_IN*DW | Output the granted cell goes to |

## Verification
The hardest situation to reach is one where a deep window entry wins only because of the exact pass order and the exact pointer state. For that to happen, an input must lose at depth 0, a competitor must be blocked from a later pass, and the pointers must have been moved by earlier slots. The bench reaches these cases with a long deterministic pseudo-random run at several request densities. Each slot goes through an independent model of the pass and pointer rules, and the model's pointers are carried across slots. Directed slots add a case where every input contends for one output, to check pointer rotation, and a case where nothing is valid.

// File: rtl/wh_pkg.sv
package wh_pkg;
  // index of the slot following idx in a ring of n entries
  function automatic int rr_after(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // position base+k folded into a ring of n entries
  function automatic int rr_slot(input int base, input int k, input int n);
    int s;
    s = base + k;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/wh_pass.sv
module wh_pass
  import wh_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int DW   = 2
) (
  input  logic [N_IN-1:0]    in_free,
  input  logic [N_IN-1:0]    out_free,
  input  logic [N_IN-1:0]    lvl_vld,
  input  logic [N_IN*DW-1:0] lvl_dst,
  input  logic [N_IN*DW-1:0] ptr,
  output logic [N_IN-1:0]    gnt,
  output logic [N_IN-1:0]    won,
  output logic [N_IN*DW-1:0] winner
);
  logic [N_IN-1:0] req_to [N_IN];

  // request matrix: output o sees input i when both are still free
  always_comb begin
    for (int o = 0; o < N_IN; o++) begin
      for (int i = 0; i < N_IN; i++) begin
        req_to[o][i] = in_free[i] && lvl_vld[i] && out_free[o] &&
                       (lvl_dst[i*DW +: DW] == DW'(o));
      end
    end
  end

  // round-robin choice per output
  always_comb begin
    int s;
    won    = '0;
    winner = '0;
    for (int o = 0; o < N_IN; o++) begin
      for (int k = 0; k < N_IN; k++) begin
        s = rr_slot(int'(ptr[o*DW +: DW]), k, N_IN);
        if (!won[o] && req_to[o][s]) begin
          won[o]              = 1'b1;
          winner[o*DW +: DW]  = DW'(s);
        end
      end
    end
  end

  // each input requests one output per depth, so a match is unique
  always_comb begin
    logic [DW-1:0] d;
    for (int i = 0; i < N_IN; i++) begin
      d = lvl_dst[i*DW +: DW];
      gnt[i] = in_free[i] && lvl_vld[i] && won[d] &&
               (winner[d*DW +: DW] == DW'(i));
    end
  end
endmodule

// File: rtl/wh_ptr_bank.sv
module wh_ptr_bank
  import wh_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int DW   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_start,
  input  logic [N_IN-1:0]    upd_en,
  input  logic [N_IN*DW-1:0] upd_win,
  output logic [N_IN*DW-1:0] ptr
);
  logic [N_IN*DW-1:0] ptr_q, ptr_n;

  always_comb begin
    ptr_n = ptr_q;
    for (int o = 0; o < N_IN; o++) begin
      if (slot_start && upd_en[o])
        ptr_n[o*DW +: DW] = DW'(rr_after(int'(upd_win[o*DW +: DW]), N_IN));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_n;
  end

  assign ptr = ptr_q;

  // R8: pointers move only inside a slot
  assert_ptr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> $stable(ptr_q));
  // R8: an output without a grant keeps its pointer
  generate
    for (genvar o = 0; o < N_IN; o++) begin : g_chk
      assert_ptr_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && !upd_en[o]) |=> $stable(ptr_q[o*DW +: DW]));
    end
  endgenerate
endmodule

// File: rtl/wh_arbiter.sv
module wh_arbiter
  import wh_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int WIN  = 2,
  localparam int DW  = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int PW  = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   slot_start,
  input  logic [N_IN*WIN-1:0]    req_valid,
  input  logic [N_IN*WIN*DW-1:0] req_dest,
  output logic [N_IN-1:0]        grant_valid,
  output logic [N_IN*PW-1:0]     grant_pos,
  output logic [N_IN*DW-1:0]     grant_dest
);
  logic [N_IN-1:0]    in_free  [WIN+1];
  logic [N_IN-1:0]    out_free [WIN+1];
  logic [N_IN-1:0]    lvl_vld  [WIN];
  logic [N_IN*DW-1:0] lvl_dst  [WIN];
  logic [N_IN-1:0]    p_gnt    [WIN];
  logic [N_IN-1:0]    p_won    [WIN];
  logic [N_IN*DW-1:0] p_win    [WIN];
  logic [N_IN*DW-1:0] ptr;
  logic [N_IN-1:0]    upd_en;
  logic [N_IN*DW-1:0] upd_win;

  logic [N_IN-1:0]    nxt_vld, vld_q;
  logic [N_IN*PW-1:0] nxt_pos, pos_q;
  logic [N_IN*DW-1:0] nxt_dst, dst_q;

  assign in_free[0]  = '1;
  assign out_free[0] = '1;

  generate
    for (genvar d = 0; d < WIN; d++) begin : g_lvl
      for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign lvl_vld[d][i]            = req_valid[i*WIN + d];
        assign lvl_dst[d][i*DW +: DW]   = req_dest[(i*WIN + d)*DW +: DW];
      end
      wh_pass #(.N_IN(N_IN), .DW(DW)) u_pass (
        .in_free (in_free[d]),
        .out_free(out_free[d]),
        .lvl_vld (lvl_vld[d]),
        .lvl_dst (lvl_dst[d]),
        .ptr     (ptr),
        .gnt     (p_gnt[d]),
        .won     (p_won[d]),
        .winner  (p_win[d])
      );
      assign in_free[d+1]  = in_free[d]  & ~p_gnt[d];
      assign out_free[d+1] = out_free[d] & ~p_won[d];
    end
  endgenerate

  // merge pass results into one grant vector and pointer update
  always_comb begin
    nxt_vld = '0;
    nxt_pos = '0;
    nxt_dst = '0;
    upd_en  = '0;
    upd_win = '0;
    for (int d = 0; d < WIN; d++) begin
      for (int i = 0; i < N_IN; i++) begin
        if (p_gnt[d][i]) begin
          nxt_vld[i]            = 1'b1;
          nxt_pos[i*PW +: PW]   = PW'(d);
          nxt_dst[i*DW +: DW]   = lvl_dst[d][i*DW +: DW];
        end
        if (p_won[d][i]) begin
          upd_en[i]             = 1'b1;
          upd_win[i*DW +: DW]   = p_win[d][i*DW +: DW];
        end
      end
    end
  end

  wh_ptr_bank #(.N_IN(N_IN), .DW(DW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_start(slot_start),
    .upd_en    (upd_en),
    .upd_win   (upd_win),
    .ptr       (ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      pos_q <= '0;
      dst_q <= '0;
    end else if (slot_start) begin
      vld_q <= nxt_vld;
      pos_q <= nxt_pos;
      dst_q <= nxt_dst;
    end
  end

  assign grant_valid = vld_q;
  assign grant_pos   = pos_q;
  assign grant_dest  = dst_q;

  // ---------------- assertions ----------------
  logic [N_IN-1:0] hit_q [N_IN];
  always_comb begin
    for (int o = 0; o < N_IN; o++)
      for (int i = 0; i < N_IN; i++)
        hit_q[o][i] = vld_q[i] && (dst_q[i*DW +: DW] == DW'(o));
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_start |=> ($stable(grant_valid) && $stable(grant_pos) && $stable(grant_dest)));

  generate
    for (genvar o = 0; o < N_IN; o++) begin : g_out_chk
      assert_one_per_output_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(hit_q[o]) <= 1);
    end
    for (genvar i = 0; i < N_IN; i++) begin : g_in_chk
      assert_grant_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_start && nxt_vld[i]) |->
          (req_valid[i*WIN + int'(nxt_pos[i*PW +: PW])] &&
           (nxt_dst[i*DW +: DW] ==
            req_dest[(i*WIN + int'(nxt_pos[i*PW +: PW]))*DW +: DW])));
      for (genvar d = 0; d < WIN; d++) begin : g_dep
        assert_maximal_R7: assert property (@(posedge clk) disable iff (!rst_n)
          (slot_start && req_valid[i*WIN + d] && !nxt_vld[i]) |->
            !out_free[WIN][req_dest[(i*WIN + d)*DW +: DW]]);
      end
    end
  endgenerate
endmodule

// File: tb/tb_wh_arbiter.sv
module tb_wh_arbiter;
  localparam int N  = 4;
  localparam int W  = 2;
  localparam int DW = 2;
  localparam int PW = 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              slot_start;
  logic [N*W-1:0]    req_valid;
  logic [N*W*DW-1:0] req_dest;
  logic [N-1:0]      grant_valid;
  logic [N*PW-1:0]   grant_pos;
  logic [N*DW-1:0]   grant_dest;

  int checks = 0;
  int fails  = 0;
  int mptr [N];
  int e_v [N];
  int e_p [N];
  int e_d [N];
  logic [31:0] rng = 32'h1234_5678;

  wh_arbiter #(.N_IN(N), .WIN(W)) dut (
    .clk(clk), .rst_n(rst_n), .slot_start(slot_start),
    .req_valid(req_valid), .req_dest(req_dest),
    .grant_valid(grant_valid), .grant_pos(grant_pos), .grant_dest(grant_dest)
  );

  always #5 clk = ~clk;

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // reference: depth-ordered passes, round-robin per output
  task automatic model();
    int inf [N];
    int outf [N];
    for (int i = 0; i < N; i++) begin inf[i] = 1; outf[i] = 1; e_v[i] = 0; e_p[i] = 0; e_d[i] = 0; end
    for (int d = 0; d < W; d++) begin
      for (int o = 0; o < N; o++) begin
        if (outf[o] == 1) begin
          for (int k = 0; k < N; k++) begin
            int s;
            s = (mptr[o] + k) % N;
            if (outf[o] == 1 && inf[s] == 1 && req_valid[s*W+d] &&
                int'(req_dest[(s*W+d)*DW +: DW]) == o) begin
              outf[o] = 0; inf[s] = 0;
              e_v[s] = 1; e_p[s] = d; e_d[s] = o;
              mptr[o] = (s + 1) % N;
            end
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < N; i++) begin
      int av, ap, ad;
      av = int'(grant_valid[i]);
      ap = av ? int'(grant_pos[i*PW +: PW]) : 0;
      ad = av ? int'(grant_dest[i*DW +: DW]) : 0;
      checks++;
      if (av != e_v[i] || ap != e_p[i] || ad != e_d[i]) begin
        fails++;
        $display("FAIL %s input %0d: got v=%0d pos=%0d dest=%0d expected v=%0d pos=%0d dest=%0d",
                 tag, i, av, ap, ad, e_v[i], e_p[i], e_d[i]);
      end
    end
  endtask

  // drive at negedge, strobe one edge, check at the following negedge
  task automatic run_slot(input string tag);
    slot_start = 1'b1;
    model();
    @(negedge clk);
    slot_start = 1'b0;
    compare(tag);
  endtask

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int o = 0; o < N; o++) mptr[o] = 0;
    rst_n = 1'b0; slot_start = 1'b0; req_valid = '0; req_dest = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (grant_valid !== '0 || grant_pos !== '0 || grant_dest !== '0) begin
      fails++;
      $display("FAIL R1 reset: got v=%h p=%h d=%h expected 0 0 0", grant_valid, grant_pos, grant_dest);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R5: nothing valid, no grant, no pointer motion (seen in later R8 slot)
    req_valid = '0; req_dest = '1;
    run_slot("R5 empty window");

    // R8: all inputs contend for output 0 at depth 0; winners rotate 0,1,2,3,0
    for (int r = 0; r < 5; r++) begin
      req_valid = '0; req_dest = '0;
      for (int i = 0; i < N; i++) req_valid[i*W] = 1'b1;
      run_slot("R8 rotation");
      checks++;
      if (!grant_valid[r % N]) begin
        fails++;
        $display("FAIL R8 rotation slot %0d: got winner mask %b expected input %0d", r, grant_valid, r % N);
      end
    end

    // R6: depth-1 entries only reach outputs left free by depth 0
    req_valid = '1;
    for (int i = 0; i < N; i++) begin
      req_dest[(i*W)*DW +: DW]   = DW'(i % 2);
      req_dest[(i*W+1)*DW +: DW] = DW'(2 + (i % 2));
    end
    run_slot("R6 deep window");

    // R2: change inputs without strobe; outputs must hold
    begin
      logic [N-1:0] hv; logic [N*PW-1:0] hp; logic [N*DW-1:0] hd;
      hv = grant_valid; hp = grant_pos; hd = grant_dest;
      req_valid = '1; req_dest = '0;
      repeat (3) @(negedge clk);
      checks++;
      if (grant_valid !== hv || grant_pos !== hp || grant_dest !== hd) begin
        fails++;
        $display("FAIL R2 hold: got v=%h p=%h d=%h expected v=%h p=%h d=%h",
                 grant_valid, grant_pos, grant_dest, hv, hp, hd);
      end
    end

    // R3 R4 R5 R6 R7 R8: pseudo-random sweep over densities
    for (int s = 0; s < 3000; s++) begin
      int dens;
      dens = s % 4;
      for (int e = 0; e < N*W; e++) begin
        rng = nxt(rng);
        req_valid[e] = (int'(rng[3:2]) <= dens);
        req_dest[e*DW +: DW] = rng[9:8];
      end
      run_slot("R3 R4 R6 R7 R8 sweep");
      if (s % 7 == 3) @(negedge clk);
    end

    finish_run();
  end
endmodule